// File: doc/BRIEF.md
# Blit Parameter Front End

This block is the register front end of a 2D block-transfer engine. Software writes source and destination coordinates, the transfer size, pitch and offset values and a master control word. Several packed alias registers set two fields in one write. A combined pitch/offset word and the master control word are each split into several internal fields. The block keeps a software-visible shadow copy of every parameter and a second, active copy that drives the engine.

A write to any register that carries the width field requests a launch. When the engine is idle, the shadow is copied into the active set and a one-cycle start pulse is issued. The pulse appears in the cycle right after the write, so the engine always sees the updated fields. While the engine reports busy, a launch request is held pending. Writes made during busy change only the shadow, and the copy and pulse wait until busy drops. A status register always reports a fixed number of free command slots, so software never has to wait.

Top module: `blit_front_end`

## Requirements
- R1: After reset, startPulse is 0, every active output is 0 and every parameter register reads back 0.
- R2: Register indices 0 to 5 (source x, source y, destination x, destination y, width, height) each store wrData[13:0] and read back zero-extended.
- R3: Index 6 (source) and 7 (destination) take x from wrData[13:0] and y from wrData[29:16]. Index 8 (source) and 9 (destination) take y from wrData[13:0] and x from wrData[29:16].
- R4: Index 10 takes width from [13:0] and height from [29:16]. Index 11 takes destination x from [13:0] and width from [29:16]. Index 12 takes height from [13:0] and width from [29:16]. Index 13 takes destination y from [13:0] and height from [29:16].
- R5: A write to index 4, 10, 11 or 12 while engBusy is low makes startPulse high for exactly the next cycle. In that cycle the active outputs equal the newly written parameter set.
- R6: The active outputs change only in a cycle in which startPulse is high. Writes to any other index never produce a start.
- R7: Index 14 (source) and 15 (destination) set offset = wrData[20:0] shifted left by 5, pitch = wrData[30:21] and tile = wrData[31].
- R8: Offset writes (16 source, 17 destination) keep wrData & 0xFFFFFFF0. Pitch writes (18 source, 19 destination) keep pitch = wrData[13:0] and tile = wrData[16]. A pitch register reads back with the pitch in [13:0] and the tile flag in bit 16.
- R9: Index 20 stores wrData & 0xF800000F as the master word. It also sets the data-type word (read-only at index 21): bits [3:0] = wrData[11:8], bits [11:8] = wrData[7:4], bits [17:16] = wrData[13:12], bit 30 = wrData[14], all other bits zero.
- R10: While engBusy is high at a clock edge, no start is issued at that edge, and a launch request is kept pending. The pending start is issued in the cycle after the first edge with engBusy low, carrying every shadow write made in the meantime.
- R11: Index 22 always reads FREE_SLOTS (default 64), and writes to it are ignored. Indices 23 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register index of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Register index of the read |
| rdData | output | 32 | Combinational readback of the shadow set |
| engBusy | input | 1 | Engine busy; launches are deferred while high |
| startPulse | output | 1 | One-cycle launch to the engine |
| actSrcX | output | 14 | Active source x |
| actSrcY | output | 14 | Active source y |
| actDstX | output | 14 | Active destination x |
| actDstY | output | 14 | Active destination y |
| actWidth | output | 14 | Active width |
| actHeight | output | 14 | Active height |
| actSrcOffset | output | 32 | Active source offset |
| actDstOffset | output | 32 | Active destination offset |
| actSrcPitch | output | 14 | Active source pitch |
| actDstPitch | output | 14 | Active destination pitch |
| actSrcTile | output | 1 | Active source tile flag |
| actDstTile | output | 1 | Active destination tile flag |
| actMaster | output | 32 | Active master control word |
| actDataType | output | 32 | Active data-type word |

## Verification
A write is registered at one clock edge. The shadow readback, the start pulse and the active copy all reflect it in the cycle after that edge. A deferred launch appears in the cycle after the first edge that samples engBusy low. The bench drives each input on the falling edge and updates its own expected model as of the following rising edge. It compares startPulse, the active outputs and the readback for the previous read index on the next falling edge. Directed reads drive rdAddr with no write pending and compare after a short settle delay, since readback is combinational.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int COORD_W = 14;
  localparam int PITCH_W = 14;
  localparam int DATA_W  = 32;
  localparam int REG_AW  = 5;

  typedef enum logic [REG_AW-1:0] {
    REG_SRC_X        = 5'd0,
    REG_SRC_Y        = 5'd1,
    REG_DST_X        = 5'd2,
    REG_DST_Y        = 5'd3,
    REG_WIDTH        = 5'd4,
    REG_HEIGHT       = 5'd5,
    REG_SRC_YX       = 5'd6,
    REG_DST_YX       = 5'd7,
    REG_SRC_XY       = 5'd8,
    REG_DST_XY       = 5'd9,
    REG_HEIGHT_WIDTH = 5'd10,
    REG_WIDTH_X      = 5'd11,
    REG_WIDTH_HEIGHT = 5'd12,
    REG_HEIGHT_Y     = 5'd13,
    REG_SRC_PO       = 5'd14,
    REG_DST_PO       = 5'd15,
    REG_SRC_OFFSET   = 5'd16,
    REG_DST_OFFSET   = 5'd17,
    REG_SRC_PITCH    = 5'd18,
    REG_DST_PITCH    = 5'd19,
    REG_MASTER       = 5'd20,
    REG_DATATYPE     = 5'd21,
    REG_STATUS       = 5'd22
  } blitReg_e;

  typedef struct packed {
    logic [COORD_W-1:0] srcX;
    logic [COORD_W-1:0] srcY;
    logic [COORD_W-1:0] dstX;
    logic [COORD_W-1:0] dstY;
    logic [COORD_W-1:0] width;
    logic [COORD_W-1:0] height;
    logic [DATA_W-1:0]  srcOffset;
    logic [DATA_W-1:0]  dstOffset;
    logic [PITCH_W-1:0] srcPitch;
    logic [PITCH_W-1:0] dstPitch;
    logic               srcTile;
    logic               dstTile;
    logic [DATA_W-1:0]  master;
    logic [DATA_W-1:0]  dataType;
  } blitParams_t;

  typedef struct packed {
    logic wr;      // store the write into the shadow set
    logic commit;  // copy the next shadow into the active set
  } blitStrobe_t;

  function automatic logic isLaunchReg(logic [REG_AW-1:0] a);
    return (a == REG_WIDTH) || (a == REG_HEIGHT_WIDTH) ||
           (a == REG_WIDTH_X) || (a == REG_WIDTH_HEIGHT);
  endfunction
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic              engBusy,
  output blitStrobe_t       strobe,
  output logic              startPulse
);
  logic launchReq;
  logic pending;
  logic issue;

  assign launchReq = wrEn && isLaunchReg(wrAddr);
  assign issue     = (launchReq || pending) && !engBusy;

  always_comb begin
    strobe.wr     = wrEn;
    strobe.commit = issue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      pending    <= (launchReq || pending) && engBusy;
      startPulse <= issue;
    end
  end
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int FREE_SLOTS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  blitStrobe_t       strobe,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output blitParams_t       active
);
  localparam logic [COORD_W-1:0] COORD_MASK  = '1;
  localparam logic [DATA_W-1:0]  OFFSET_MASK = 32'hFFFF_FFF0;
  localparam logic [DATA_W-1:0]  MASTER_MASK = 32'hF800_000F;

  blitParams_t shadow;
  blitParams_t nextShadow;

  logic [COORD_W-1:0] loField;
  logic [COORD_W-1:0] hiField;
  assign loField = wrData[COORD_W-1:0] & COORD_MASK;
  assign hiField = wrData[16 +: COORD_W] & COORD_MASK;

  logic [DATA_W-1:0] poOffset;
  logic [PITCH_W-1:0] poPitch;
  assign poOffset = DATA_W'({wrData[20:0], 5'b0});
  assign poPitch  = PITCH_W'(wrData[30:21]);

  logic [DATA_W-1:0] derivedType;
  always_comb begin
    derivedType        = '0;
    derivedType[3:0]   = wrData[11:8];
    derivedType[11:8]  = wrData[7:4];
    derivedType[17:16] = wrData[13:12];
    derivedType[30]    = wrData[14];
  end

  always_comb begin
    nextShadow = shadow;
    if (strobe.wr) begin
      case (wrAddr)
        REG_SRC_X:        nextShadow.srcX = loField;
        REG_SRC_Y:        nextShadow.srcY = loField;
        REG_DST_X:        nextShadow.dstX = loField;
        REG_DST_Y:        nextShadow.dstY = loField;
        REG_WIDTH:        nextShadow.width = loField;
        REG_HEIGHT:       nextShadow.height = loField;
        REG_SRC_YX:       begin nextShadow.srcX = loField; nextShadow.srcY = hiField; end
        REG_DST_YX:       begin nextShadow.dstX = loField; nextShadow.dstY = hiField; end
        REG_SRC_XY:       begin nextShadow.srcY = loField; nextShadow.srcX = hiField; end
        REG_DST_XY:       begin nextShadow.dstY = loField; nextShadow.dstX = hiField; end
        REG_HEIGHT_WIDTH: begin nextShadow.width = loField; nextShadow.height = hiField; end
        REG_WIDTH_X:      begin nextShadow.dstX = loField; nextShadow.width = hiField; end
        REG_WIDTH_HEIGHT: begin nextShadow.height = loField; nextShadow.width = hiField; end
        REG_HEIGHT_Y:     begin nextShadow.dstY = loField; nextShadow.height = hiField; end
        REG_SRC_PO: begin
          nextShadow.srcOffset = poOffset;
          nextShadow.srcPitch  = poPitch;
          nextShadow.srcTile   = wrData[31];
        end
        REG_DST_PO: begin
          nextShadow.dstOffset = poOffset;
          nextShadow.dstPitch  = poPitch;
          nextShadow.dstTile   = wrData[31];
        end
        REG_SRC_OFFSET:   nextShadow.srcOffset = wrData & OFFSET_MASK;
        REG_DST_OFFSET:   nextShadow.dstOffset = wrData & OFFSET_MASK;
        REG_SRC_PITCH: begin
          nextShadow.srcPitch = wrData[PITCH_W-1:0];
          nextShadow.srcTile  = wrData[16];
        end
        REG_DST_PITCH: begin
          nextShadow.dstPitch = wrData[PITCH_W-1:0];
          nextShadow.dstTile  = wrData[16];
        end
        REG_MASTER: begin
          nextShadow.master   = wrData & MASTER_MASK;
          nextShadow.dataType = derivedType;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (strobe.wr)     shadow <= nextShadow;
      if (strobe.commit) active <= nextShadow;
    end
  end

  function automatic logic [DATA_W-1:0] pitchWord(logic [PITCH_W-1:0] p, logic t);
    logic [DATA_W-1:0] w;
    w             = '0;
    w[PITCH_W-1:0] = p;
    w[16]         = t;
    return w;
  endfunction

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_SRC_X:      rdData = DATA_W'(shadow.srcX);
      REG_SRC_Y:      rdData = DATA_W'(shadow.srcY);
      REG_DST_X:      rdData = DATA_W'(shadow.dstX);
      REG_DST_Y:      rdData = DATA_W'(shadow.dstY);
      REG_WIDTH:      rdData = DATA_W'(shadow.width);
      REG_HEIGHT:     rdData = DATA_W'(shadow.height);
      REG_SRC_OFFSET: rdData = shadow.srcOffset;
      REG_DST_OFFSET: rdData = shadow.dstOffset;
      REG_SRC_PITCH:  rdData = pitchWord(shadow.srcPitch, shadow.srcTile);
      REG_DST_PITCH:  rdData = pitchWord(shadow.dstPitch, shadow.dstTile);
      REG_MASTER:     rdData = shadow.master;
      REG_DATATYPE:   rdData = shadow.dataType;
      REG_STATUS:     rdData = DATA_W'(FREE_SLOTS);
      default:        rdData = '0;
    endcase
  end
endmodule

// File: rtl/blit_front_end.sv
module blit_front_end
  import blit_pkg::*;
#(
  parameter int FREE_SLOTS = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_AW-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [REG_AW-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic               engBusy,
  output logic               startPulse,
  output logic [COORD_W-1:0] actSrcX,
  output logic [COORD_W-1:0] actSrcY,
  output logic [COORD_W-1:0] actDstX,
  output logic [COORD_W-1:0] actDstY,
  output logic [COORD_W-1:0] actWidth,
  output logic [COORD_W-1:0] actHeight,
  output logic [DATA_W-1:0]  actSrcOffset,
  output logic [DATA_W-1:0]  actDstOffset,
  output logic [PITCH_W-1:0] actSrcPitch,
  output logic [PITCH_W-1:0] actDstPitch,
  output logic               actSrcTile,
  output logic               actDstTile,
  output logic [DATA_W-1:0]  actMaster,
  output logic [DATA_W-1:0]  actDataType
);
  blitStrobe_t strobe;
  blitParams_t active;

  blit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .engBusy(engBusy), .strobe(strobe), .startPulse(startPulse)
  );

  blit_datapath #(.FREE_SLOTS(FREE_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .active(active)
  );

  assign actSrcX      = active.srcX;
  assign actSrcY      = active.srcY;
  assign actDstX      = active.dstX;
  assign actDstY      = active.dstY;
  assign actWidth     = active.width;
  assign actHeight    = active.height;
  assign actSrcOffset = active.srcOffset;
  assign actDstOffset = active.dstOffset;
  assign actSrcPitch  = active.srcPitch;
  assign actDstPitch  = active.dstPitch;
  assign actSrcTile   = active.srcTile;
  assign actDstTile   = active.dstTile;
  assign actMaster    = active.master;
  assign actDataType  = active.dataType;
endmodule

// File: rtl/blit_front_end_chk.sv
module blit_front_end_chk
  import blit_pkg::*;
#(
  parameter int FREE_SLOTS = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [REG_AW-1:0]  wrAddr,
  input logic               engBusy,
  input logic               startPulse,
  input logic [REG_AW-1:0]  rdAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic [COORD_W-1:0] actWidth,
  input logic [COORD_W-1:0] actHeight,
  input logic [COORD_W-1:0] actDstX,
  input logic [DATA_W-1:0]  actSrcOffset,
  input logic [DATA_W-1:0]  actMaster
);
  logic isLaunch;
  assign isLaunch = wrEn && ((wrAddr == 5'd4) || (wrAddr == 5'd10) ||
                             (wrAddr == 5'd11) || (wrAddr == 5'd12));

  assert_start_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isLaunch && !engBusy) |=> startPulse);

  assert_active_only_on_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({actWidth, actHeight, actDstX, actSrcOffset, actMaster}) |-> startPulse);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |=> !startPulse);

  assert_status_slots_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 5'd22) |-> (rdData == DATA_W'(FREE_SLOTS)));

  assert_offset_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 5'd17) |-> (rdData[3:0] == 4'd0));
endmodule

bind blit_front_end blit_front_end_chk #(.FREE_SLOTS(FREE_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .engBusy(engBusy),
  .startPulse(startPulse), .rdAddr(rdAddr), .rdData(rdData),
  .actWidth(actWidth), .actHeight(actHeight), .actDstX(actDstX),
  .actSrcOffset(actSrcOffset), .actMaster(actMaster)
);

// File: tb/sim_blit_front_end.sv
`timescale 1ns/1ps
module sim_blit_front_end;
  import blit_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0] rdAddr = '0;
  logic [31:0] rdData;
  logic engBusy = 1'b0;
  logic startPulse;
  logic [13:0] actSrcX, actSrcY, actDstX, actDstY, actWidth, actHeight;
  logic [31:0] actSrcOffset, actDstOffset;
  logic [13:0] actSrcPitch, actDstPitch;
  logic actSrcTile, actDstTile;
  logic [31:0] actMaster, actDataType;

  always #10 clk = ~clk;  // 50 MHz

  blit_front_end u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engBusy(engBusy), .startPulse(startPulse),
    .actSrcX(actSrcX), .actSrcY(actSrcY), .actDstX(actDstX), .actDstY(actDstY),
    .actWidth(actWidth), .actHeight(actHeight), .actSrcOffset(actSrcOffset),
    .actDstOffset(actDstOffset), .actSrcPitch(actSrcPitch), .actDstPitch(actDstPitch),
    .actSrcTile(actSrcTile), .actDstTile(actDstTile), .actMaster(actMaster),
    .actDataType(actDataType)
  );

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  blitParams_t expSh = '0;
  blitParams_t expAct = '0;
  bit expPend = 1'b0;
  bit expStart = 1'b0;
  bit lastBusyPath = 1'b0;
  logic [4:0] lastRa = '0;
  string lastReq = "R1";

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic blitParams_t benchApply(blitParams_t s, logic [4:0] a, logic [31:0] d);
    logic [13:0] lo = d[13:0];
    logic [13:0] hi = 14'((d >> 16) & 32'h3FFF);
    blitParams_t n = s;
    case (a)
      5'd0: n.srcX = lo;   5'd1: n.srcY = lo;
      5'd2: n.dstX = lo;   5'd3: n.dstY = lo;
      5'd4: n.width = lo;  5'd5: n.height = lo;
      5'd6: begin n.srcX = lo; n.srcY = hi; end
      5'd7: begin n.dstX = lo; n.dstY = hi; end
      5'd8: begin n.srcY = lo; n.srcX = hi; end
      5'd9: begin n.dstY = lo; n.dstX = hi; end
      5'd10: begin n.width = lo; n.height = hi; end
      5'd11: begin n.dstX = lo; n.width = hi; end
      5'd12: begin n.height = lo; n.width = hi; end
      5'd13: begin n.dstY = lo; n.height = hi; end
      5'd14: begin n.srcOffset = (d & 32'h001F_FFFF) * 32; n.srcPitch = 14'((d >> 21) & 32'h3FF); n.srcTile = d[31]; end
      5'd15: begin n.dstOffset = (d & 32'h001F_FFFF) * 32; n.dstPitch = 14'((d >> 21) & 32'h3FF); n.dstTile = d[31]; end
      5'd16: n.srcOffset = {d[31:4], 4'h0};
      5'd17: n.dstOffset = {d[31:4], 4'h0};
      5'd18: begin n.srcPitch = lo; n.srcTile = d[16]; end
      5'd19: begin n.dstPitch = lo; n.dstTile = d[16]; end
      5'd20: begin
        n.master = {d[31:27], 23'd0, d[3:0]};
        n.dataType = ((d >> 8) & 32'hF) | ((d & 32'h30F0) << 4) | ((d & 32'h4000) << 16);
      end
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic [31:0] benchRead(blitParams_t s, logic [4:0] a);
    case (a)
      5'd0: return {18'd0, s.srcX};
      5'd1: return {18'd0, s.srcY};
      5'd2: return {18'd0, s.dstX};
      5'd3: return {18'd0, s.dstY};
      5'd4: return {18'd0, s.width};
      5'd5: return {18'd0, s.height};
      5'd16: return s.srcOffset;
      5'd17: return s.dstOffset;
      5'd18: return {15'd0, s.srcTile, 2'd0, s.srcPitch};
      5'd19: return {15'd0, s.dstTile, 2'd0, s.dstPitch};
      5'd20: return s.master;
      5'd21: return s.dataType;
      5'd22: return 32'd64;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit benchLaunch(logic [4:0] a);
    return a == 5'd4 || a == 5'd10 || a == 5'd11 || a == 5'd12;
  endfunction

  // One cycle: check outputs due from the previous cycle, then drive new inputs.
  task automatic step(bit wr, logic [4:0] a, logic [31:0] d, bit busy, logic [4:0] ra, string req);
    bit trig;
    @(negedge clk);
    chk(startPulse == expStart, lastBusyPath ? "R10 start" : "R5 start", 256'(startPulse), 256'(expStart));
    chk({actSrcX, actSrcY, actDstX, actDstY, actWidth, actHeight, actSrcOffset, actDstOffset,
         actSrcPitch, actDstPitch, actSrcTile, actDstTile, actMaster, actDataType} == expAct,
        "R6 active", 256'({actWidth, actHeight, actDstX}), 256'({expAct.width, expAct.height, expAct.dstX}));
    chk(rdData == benchRead(expSh, lastRa), lastReq, 256'(rdData), 256'(benchRead(expSh, lastRa)));
    wrEn = wr; wrAddr = a; wrData = d; engBusy = busy; rdAddr = ra;
    trig = wr && benchLaunch(a);
    lastBusyPath = busy || expPend;
    if (wr) expSh = benchApply(expSh, a, d);
    expStart = (trig || expPend) && !busy;
    expPend  = (trig || expPend) && busy;
    if (expStart) expAct = expSh;
    lastRa = ra;
    lastReq = req;
  endtask

  task automatic readChk(logic [4:0] a, logic [31:0] exp, string req);
    step(1'b0, 5'd0, 32'd0, engBusy, a, req);
    #1;
    chk(rdData == exp, req, 256'(rdData), 256'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(startPulse == 1'b0, "R1 start", 256'(startPulse), 256'(0));
    chk(actWidth == 0 && actMaster == 0 && actSrcOffset == 0, "R1 active", 256'(actWidth), 256'(0));
    rstN = 1'b1;
    for (int i = 0; i < 22; i++) readChk(5'(i), 32'd0, "R1 readback");

    // R2 direct coordinates, masked to 14 bits
    step(1'b1, 5'd2, 32'hFFFF_C123, 1'b0, 5'd2, "R2");
    readChk(5'd2, 32'h0000_0123, "R2 dstX mask");
    // R3 packed coordinate aliases
    step(1'b1, 5'd6, 32'hC123_F456, 1'b0, 5'd0, "R3");
    readChk(5'd0, 32'h0000_3456, "R3 srcX yx");
    readChk(5'd1, 32'h0000_0123, "R3 srcY yx");
    step(1'b1, 5'd9, 32'h0005_0007, 1'b0, 5'd2, "R3");
    readChk(5'd2, 32'd5, "R3 dstX xy");
    readChk(5'd3, 32'd7, "R3 dstY xy");
    // R4 size aliases: HEIGHT_Y no launch, WIDTH_X launches (R5)
    step(1'b1, 5'd13, 32'h0020_0010, 1'b0, 5'd5, "R4");
    readChk(5'd5, 32'h20, "R4 height");
    step(1'b1, 5'd11, 32'h0030_0008, 1'b0, 5'd4, "R4");
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd4, "R4");
    chk(actWidth == 14'h30 && actDstX == 14'h8, "R5 active width", 256'(actWidth), 256'(14'h30));
    step(1'b1, 5'd12, 32'h0011_0022, 1'b0, 5'd5, "R4");
    readChk(5'd5, 32'h22, "R4 height wh");
    readChk(5'd4, 32'h11, "R4 width wh");
    // R7 packed pitch/offset
    step(1'b1, 5'd14, 32'hFFFF_FFFF, 1'b0, 5'd16, "R7");
    readChk(5'd16, 32'h03FF_FFE0, "R7 offset");
    readChk(5'd18, 32'h0001_03FF, "R7 pitch tile");
    // R8 direct offset and pitch
    step(1'b1, 5'd17, 32'h1234_567F, 1'b0, 5'd17, "R8");
    readChk(5'd17, 32'h1234_5670, "R8 offset");
    step(1'b1, 5'd19, 32'hFFFF_FFFF, 1'b0, 5'd19, "R8");
    readChk(5'd19, 32'h0001_3FFF, "R8 pitch");
    // R9 master and data type
    step(1'b1, 5'd20, 32'hFFFF_FFFF, 1'b0, 5'd20, "R9");
    readChk(5'd20, 32'hF800_000F, "R9 master");
    readChk(5'd21, 32'h4003_0F0F, "R9 datatype");
    step(1'b1, 5'd20, 32'h0000_4A5C, 1'b0, 5'd21, "R9");
    readChk(5'd21, 32'h4000_050A, "R9 datatype b");
    readChk(5'd20, 32'h0000_000C, "R9 master b");
    // R11 status and unmapped
    step(1'b1, 5'd22, 32'h0, 1'b0, 5'd22, "R11");
    readChk(5'd22, 32'd64, "R11 status");
    readChk(5'd27, 32'd0, "R11 unmapped");
    // R10 launch while busy, extra writes, then release
    step(1'b1, 5'd4, 32'h0000_0100, 1'b1, 5'd4, "R10");
    step(1'b1, 5'd5, 32'h0000_0050, 1'b1, 5'd5, "R10");
    step(1'b0, 5'd0, 32'd0, 1'b1, 5'd5, "R10");
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd5, "R10");
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd5, "R10");
    chk(actWidth == 14'h100 && actHeight == 14'h50, "R10 deferred set", 256'({actWidth, actHeight}), 256'({14'h100, 14'h50}));
    // R6 non-launch write leaves active alone
    step(1'b1, 5'd0, 32'h0000_0777, 1'b0, 5'd0, "R6");
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd0, "R6");
    chk(actSrcX != 14'h777, "R6 srcX held", 256'(actSrcX), 256'(0));

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a = 5'($urandom % 24);
      step(($urandom % 4) != 0, a, $urandom, ($urandom % 4) == 0, 5'($urandom % 24), "R2 random");
    end
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd0, "R2");
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd0, "R2");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule